// File: doc/BRIEF.md
# Ternary CAM Search Engine

This block is a ternary content-addressable table. Each entry holds a data word, a per-entry ignore mask and a two-bit state. One compare checks the key register against every entry at once. It returns three results:

- whether any entry matched;
- whether more than one entry matched;
- the index of the lowest matching entry.

A bit position is ignored when any of three masks marks it. These are the entry's own mask, a configuration mask that always applies, and, optionally, one of two global masks selected for that operation. The global masks also protect stored data bits during entry writes.

The host loads entries, mask registers and the key over plain write strobes. It then pulses `cmp_en` together with a global-mask selector. The result appears one cycle later, marked by a single-cycle `res_valid`. The result interface has no back-pressure: a result is never stalled or queued. Each new compare replaces the previous result, so a consumer that must keep a result captures it in the cycle `res_valid` is high. The block accepts a compare on every cycle.

Top module: `tcam_search`

## Requirements
- R1: After reset every entry is Empty (state code 2'b00), both global masks, the configuration mask and the key register are zero, and `hit`, `multi`, `res_valid` and `hit_idx` are 0.
- R2: `res_valid` is 1 in exactly the cycle after a cycle with `cmp_en` high, and 0 otherwise.
- R3: An entry matches when, for every bit not ignored, its stored data equals the key. A bit is ignored when the entry's own mask, the configuration mask or the selected global mask has a 1 there.
- R4: Only entries in state Valid (2'b01) can match. Empty (2'b00), Skip (2'b10) and RAM (2'b11) entries never match.
- R5: `hit_idx` gives the lowest matching index. It is 0 when nothing matches.
- R6: `multi` is 1 when two or more entries match, and `hit` is 1 when at least one entry matches.
- R7: The global-mask selector uses this encoding: 2'b01 selects mask 0, 2'b10 selects mask 1, and 2'b00 and 2'b11 select no global mask.
- R8: For an entry write, a data bit stays unchanged where the write's selected global mask has a 1. The entry's own mask and its state are always written in full.
- R9: The configuration mask (`reg_sel` = 2) applies to every compare. `reg_sel` 0 and 1 load global masks 0 and 1, and `reg_sel` 3 does nothing.
- R10: `hit`, `multi` and `hit_idx` hold their values in cycles without a compare, even when entries or registers are written.
- R11: A compare uses the key, masks and entries as they were before that clock edge. A write in the same cycle takes effect only for later compares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_we | input | 1 | Entry write strobe |
| ent_addr | input | IDXW | Entry index to write |
| ent_data | input | WIDTH | Entry data word |
| ent_lmask | input | WIDTH | Entry local ignore mask |
| ent_state | input | 2 | Entry state code |
| ent_gsel | input | 2 | Global mask protecting data bits on this write |
| reg_we | input | 1 | Mask register write strobe |
| reg_sel | input | 2 | 0 global mask 0, 1 global mask 1, 2 config mask |
| reg_data | input | WIDTH | Mask register value |
| key_we | input | 1 | Key register write strobe |
| key_data | input | WIDTH | Key value |
| cmp_en | input | 1 | Compare strobe |
| cmp_gsel | input | 2 | Global mask applied to this compare |
| res_valid | output | 1 | Result produced by previous-cycle compare |
| hit | output | 1 | At least one entry matched |
| multi | output | 1 | Two or more entries matched |
| hit_idx | output | IDXW | Lowest matching index |

## Verification
Some rules hold on every cycle, and the assertions check these:

- `res_valid` follows `cmp_en` by one cycle;
- results stay stable between compares;
- `multi` never appears without `hit`;
- a miss reports index zero.

Other properties depend on the stored table, and only the bench's scenarios can show them. These are the correctness of the match itself under each mask source, the state filtering, the lowest-index choice, write protection by a global mask, and the same-cycle ordering of writes and compares. The bench checks each of these against a reference model of the table.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'b00,
    ST_VALID = 2'b01,
    ST_SKIP  = 2'b10,
    ST_RAM   = 2'b11
  } ent_state_e;

  localparam logic [1:0] GSEL_G0 = 2'b01;
  localparam logic [1:0] GSEL_G1 = 2'b10;
endpackage

// File: rtl/tcam_entry.sv
module tcam_entry
  import tcam_pkg::*;
#(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] wlmask,
  input  logic [1:0]       wstate,
  input  logic [WIDTH-1:0] wprot,
  input  logic [WIDTH-1:0] key,
  input  logic [WIDTH-1:0] xmask,
  output logic             match
);
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] lmask_q;
  ent_state_e       state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      lmask_q <= '0;
      state_q <= ST_EMPTY;
    end else if (we) begin
      data_q  <= (data_q & wprot) | (wdata & ~wprot);
      lmask_q <= wlmask;
      state_q <= ent_state_e'(wstate);
    end
  end

  always_comb begin
    match = (state_q == ST_VALID) &&
            (((data_q ^ key) & ~(lmask_q | xmask)) == '0);
  end
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int DEPTH = 16,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] req,
  output logic             any,
  output logic             many,
  output logic [IDXW-1:0]  idx
);
  always_comb begin
    logic seen;
    seen = 1'b0;
    many = 1'b0;
    idx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDXW'(i);
    end
    for (int i = 0; i < DEPTH; i++) begin
      many = many | (seen & req[i]);
      seen = seen | req[i];
    end
    any = seen;
  end
endmodule

// File: rtl/tcam_search.sv
module tcam_search
  import tcam_pkg::*;
#(
  parameter int WIDTH = 128,
  parameter int DEPTH = 16,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ent_we,
  input  logic [IDXW-1:0]  ent_addr,
  input  logic [WIDTH-1:0] ent_data,
  input  logic [WIDTH-1:0] ent_lmask,
  input  logic [1:0]       ent_state,
  input  logic [1:0]       ent_gsel,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [WIDTH-1:0] reg_data,
  input  logic             key_we,
  input  logic [WIDTH-1:0] key_data,
  input  logic             cmp_en,
  input  logic [1:0]       cmp_gsel,
  output logic             res_valid,
  output logic             hit,
  output logic             multi,
  output logic [IDXW-1:0]  hit_idx
);
  logic [WIDTH-1:0] gmask0_q, gmask1_q, cfg_q, key_q;
  logic [WIDTH-1:0] wr_prot, cmp_gm, cmp_xmask;
  logic [DEPTH-1:0] row_match;
  logic             pe_any, pe_many;
  logic [IDXW-1:0]  pe_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask0_q <= '0;
      gmask1_q <= '0;
      cfg_q    <= '0;
      key_q    <= '0;
    end else begin
      if (reg_we && reg_sel == 2'd0) gmask0_q <= reg_data;
      if (reg_we && reg_sel == 2'd1) gmask1_q <= reg_data;
      if (reg_we && reg_sel == 2'd2) cfg_q    <= reg_data;
      if (key_we) key_q <= key_data;
    end
  end

  always_comb begin
    unique case (ent_gsel)
      GSEL_G0: wr_prot = gmask0_q;
      GSEL_G1: wr_prot = gmask1_q;
      default: wr_prot = '0;
    endcase
    unique case (cmp_gsel)
      GSEL_G0: cmp_gm = gmask0_q;
      GSEL_G1: cmp_gm = gmask1_q;
      default: cmp_gm = '0;
    endcase
    cmp_xmask = cfg_q | cmp_gm;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_row
    tcam_entry #(.WIDTH(WIDTH)) u_entry (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ent_we && (ent_addr == IDXW'(e))),
      .wdata  (ent_data),
      .wlmask (ent_lmask),
      .wstate (ent_state),
      .wprot  (wr_prot),
      .key    (key_q),
      .xmask  (cmp_xmask),
      .match  (row_match[e])
    );
  end

  tcam_prio_enc #(.DEPTH(DEPTH)) u_prio (
    .req  (row_match),
    .any  (pe_any),
    .many (pe_many),
    .idx  (pe_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      hit       <= 1'b0;
      multi     <= 1'b0;
      hit_idx   <= '0;
    end else begin
      res_valid <= cmp_en;
      if (cmp_en) begin
        hit     <= pe_any;
        multi   <= pe_many;
        hit_idx <= pe_idx;
      end
    end
  end
endmodule

// File: rtl/tcam_search_chk.sv
module tcam_search_chk #(
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmp_en,
  input logic            res_valid,
  input logic            hit,
  input logic            multi,
  input logic [IDXW-1:0] hit_idx
);
  // R2: result strobe follows every compare
  a_r2_valid_after_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |=> res_valid);
  // R2: no result strobe without a compare
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> !res_valid);
  // R6: multiple match implies a match
  a_r6_multi_implies_hit: assert property (@(posedge clk) disable iff (!rst_n)
    multi |-> hit);
  // R5: a miss reports index zero
  a_r5_idx_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0));
  // R10: results hold between compares
  a_r10_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> ($stable(hit) && $stable(multi) && $stable(hit_idx)));
endmodule

bind tcam_search tcam_search_chk #(.IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_en    (cmp_en),
  .res_valid (res_valid),
  .hit       (hit),
  .multi     (multi),
  .hit_idx   (hit_idx)
);

// File: tb/sim_tcam_search.sv
`timescale 1ns/1ps
module sim_tcam_search;
  localparam int W = 128;
  localparam int D = 16;
  localparam int IW = $clog2(D);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ent_we = 0, reg_we = 0, key_we = 0, cmp_en = 0;
  logic [IW-1:0] ent_addr = '0;
  logic [W-1:0] ent_data = '0, ent_lmask = '0, reg_data = '0, key_data = '0;
  logic [1:0] ent_state = '0, ent_gsel = '0, reg_sel = '0, cmp_gsel = '0;
  logic res_valid, hit, multi;
  logic [IW-1:0] hit_idx;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_data [D];
  logic [W-1:0] m_lm [D];
  logic [1:0]   m_st [D];
  logic [W-1:0] m_g0, m_g1, m_cfg, m_key;

  always #4 clk = ~clk;

  tcam_search #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .ent_we(ent_we), .ent_addr(ent_addr),
    .ent_data(ent_data), .ent_lmask(ent_lmask), .ent_state(ent_state),
    .ent_gsel(ent_gsel), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_data(reg_data), .key_we(key_we), .key_data(key_data),
    .cmp_en(cmp_en), .cmp_gsel(cmp_gsel), .res_valid(res_valid),
    .hit(hit), .multi(multi), .hit_idx(hit_idx)
  );

  function automatic logic [W-1:0] gm(input logic [1:0] s);
    if (s == 2'b01) return m_g0;
    if (s == 2'b10) return m_g1;
    return '0;
  endfunction

  function automatic logic [D-1:0] exp_vec(input logic [1:0] s);
    logic [D-1:0] v;
    for (int e = 0; e < D; e++)
      v[e] = (m_st[e] == 2'b01) &&
             (((m_data[e] ^ m_key) & ~(m_lm[e] | m_cfg | gm(s))) == '0);
    return v;
  endfunction

  function automatic logic [W-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [W-1:0] sparse();
    return rnd() & rnd() & rnd() & rnd();
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ent(input int a, input logic [W-1:0] d, input logic [W-1:0] lm,
                        input logic [1:0] st, input logic [1:0] gs);
    @(negedge clk);
    ent_we = 1; ent_addr = IW'(a); ent_data = d; ent_lmask = lm;
    ent_state = st; ent_gsel = gs;
    m_data[a] = (m_data[a] & gm(gs)) | (d & ~gm(gs));
    m_lm[a] = lm; m_st[a] = st;
    @(negedge clk);
    ent_we = 0;
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [W-1:0] v);
    @(negedge clk);
    reg_we = 1; reg_sel = s; reg_data = v;
    if (s == 2'd0) m_g0 = v;
    if (s == 2'd1) m_g1 = v;
    if (s == 2'd2) m_cfg = v;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic ld_key(input logic [W-1:0] k);
    @(negedge clk);
    key_we = 1; key_data = k; m_key = k;
    @(negedge clk);
    key_we = 0;
  endtask

  task automatic compare(input logic [1:0] s, input string tag);
    logic [D-1:0] v;
    logic [IW-1:0] ei;
    @(negedge clk);
    v = exp_vec(s);
    ei = '0;
    for (int e = D - 1; e >= 0; e--) if (v[e]) ei = IW'(e);
    cmp_en = 1; cmp_gsel = s;
    @(negedge clk);
    cmp_en = 0;
    chk(res_valid == 1'b1, {tag, " R2 res_valid"}, W'(res_valid), 1);
    chk(hit == (v != '0), {tag, " R6 hit"}, W'(hit), W'(v != '0));
    chk(multi == ($countones(v) > 1), {tag, " R6 multi"}, W'(multi),
        W'($countones(v) > 1));
    chk(hit_idx == ei, {tag, " R5 hit_idx"}, W'(hit_idx), W'(ei));
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] k, old_h, old_m, old_i;
    void'($urandom(32'd1234));
    for (int e = 0; e < D; e++) begin m_data[e] = '0; m_lm[e] = '0; m_st[e] = 2'b00; end
    m_g0 = '0; m_g1 = '0; m_cfg = '0; m_key = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!hit && !multi && !res_valid && hit_idx == '0, "R1 outputs after reset",
        W'({hit, multi, res_valid, hit_idx}), 0);
    compare(2'b00, "R1 all empty");
    @(negedge clk);
    chk(res_valid == 0, "R2 strobe single cycle", W'(res_valid), 0);

    // R4 non-valid states never match
    wr_ent(2, 128'hA5, '0, 2'b10, 2'b00);
    wr_ent(3, 128'hA5, '0, 2'b11, 2'b00);
    wr_ent(4, 128'hA5, '0, 2'b00, 2'b00);
    ld_key(128'hA5);
    compare(2'b00, "R4 skip/ram/empty");
    // R5 R6 lowest of two matches
    wr_ent(9, 128'hA5, '0, 2'b01, 2'b00);
    wr_ent(5, 128'hA4, 128'h1, 2'b01, 2'b00);
    compare(2'b00, "R3 R5 two matches");
    // R9 config mask
    wr_ent(7, 128'hA5 ^ (128'h1 << 100), '0, 2'b01, 2'b00);
    wr_ent(5, 128'h0, '0, 2'b00, 2'b00);
    wr_ent(9, 128'h0, '0, 2'b00, 2'b00);
    compare(2'b00, "R9 before cfg");
    wr_reg(2'd2, 128'h1 << 100);
    compare(2'b00, "R9 cfg mask");
    wr_reg(2'd2, '0);
    wr_reg(2'd3, '1);
    compare(2'b00, "R9 sel3 ignored");
    // R7 global select encodings
    wr_reg(2'd1, 128'h1 << 100);
    compare(2'b01, "R7 g0");
    compare(2'b10, "R7 g1");
    compare(2'b11, "R7 none");
    // R8 write protection by global mask
    wr_reg(2'd0, 128'hFF);
    wr_ent(7, 128'h00, '0, 2'b01, 2'b01);
    ld_key(128'hA5);
    compare(2'b00, "R8 protected bits kept");
    // R10 hold across idle and writes
    old_h = W'(hit); old_m = W'(multi); old_i = W'(hit_idx);
    wr_ent(0, 128'hA5, '0, 2'b01, 2'b00);
    chk(W'(hit) == old_h && W'(multi) == old_m && W'(hit_idx) == old_i,
        "R10 hold", W'({hit, multi, hit_idx}), W'({old_h[0], old_m[0], old_i[IW-1:0]}));
    // R11 same-cycle key write and compare uses old key
    @(negedge clk);
    key_we = 1; key_data = 128'h77; cmp_en = 1; cmp_gsel = 2'b00;
    @(negedge clk);
    key_we = 0; cmp_en = 0; m_key = 128'h77;
    chk(hit == 1 && hit_idx == 0, "R11 old key used", W'({hit, hit_idx}), W'({1'b1, 4'd0}));
    compare(2'b00, "R11 new key");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4) begin
        int a;
        logic [1:0] st;
        a = int'($urandom_range(0, D - 1));
        st = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b01;
        if (op == 0) wr_ent(a, m_data[($urandom_range(0, D - 1))] ^ sparse(), sparse(), st, 2'($urandom));
        else wr_ent(a, rnd(), sparse(), st, 2'($urandom));
      end else if (op == 4) begin
        wr_reg(2'($urandom), sparse() & sparse());
      end else begin
        k = m_data[$urandom_range(0, D - 1)];
        if ($urandom_range(0, 1) == 1) k = k ^ sparse();
        ld_key(k);
        compare(2'($urandom), "R3 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule